// File: doc/BRIEF.md
# HDB3/AMI Line Encoder

This block turns a serial NRZ unipolar bit stream into two unipolar return-to-zero pulse rails. One rail carries positive marks and the other carries negative marks. Circuitry outside the block adds the two rails into a ternary line signal. A runtime select input chooses between two codes. Plain AMI sends each one as a mark of alternating polarity. HDB3 also replaces every run of four zeros with a substitution group that includes a deliberate bipolar violation.

A look-ahead pipeline of four stages holds each bit until the next three bits are known. When the four oldest held bits are all zeros, the block inserts a substitution. It uses 000V when an odd number of marks has been sent since the last violation, and B00V when that number is even. A polarity tracker alternates ordinary marks. Each rail is registered and then ANDed with the high phase of the transmit clock, so a pulse lasts half a bit period. A bit sampled on one rising edge appears on the rails four clock periods later.

Top module: `hdb3_ami_encoder`

## Requirements
- R1: `rst` is synchronous and active high. While it is asserted, and for the four clock periods after it is released, both rails stay low. Pipeline contents from before reset never produce pulses or substitutions.
- R2: A bit sampled on rising edge k decides the rail pulse during the high phase that follows rising edge k+4.
- R3: With `hdb3_mode` = 0 (AMI), every 1 gives exactly one pulse and every 0 gives none, whatever the length of a zero run.
- R4: The first mark after reset goes on the positive rail (`pos_rz`). Every later ordinary mark (a data one or a B pulse) takes the polarity opposite to the previous pulse.
- R5: With `hdb3_mode` = 1, four consecutive zeros are sent as 000V if the number of pulses sent since the last V (or since reset) is odd, and as B00V if it is even. V pulses are not counted.
- R6: A V pulse has the same polarity as the pulse just before it, and it clears the mark count used by R5.
- R7: A zero run longer than four is split into consecutive groups of four, and each group is substituted on its own. For example, eight zeros give two substitutions.
- R8: The two rails are never high together. Each rail is low whenever the clock is low.
- R9: In HDB3 mode, a run of one to three zeros between ones is sent as spaces, with no added pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit clock; data is sampled on the rising edge, and pulses occupy the high phase |
| rst | input | 1 | Synchronous active-high reset |
| nrz_in | input | 1 | Serial NRZ unipolar data bit |
| hdb3_mode | input | 1 | 1 selects HDB3 coding, 0 selects plain AMI |
| pos_rz | output | 1 | Positive-mark return-to-zero pulse rail |
| neg_rz | output | 1 | Negative-mark return-to-zero pulse rail |

## Verification
The hardest state to reach is the choice between 000V and B00V. It depends on how many marks went out since the last violation, and that count is invisible at the ports. Directed patterns start from reset with a known count and force both parities. One of them uses a run of eight zeros, so that a second substitution follows a violation directly. Long random streams with varied mark density, and with the mode flipped in the middle of a stream, are then compared cycle by cycle against a behavioural queue model. In those streams the count drifts into both states many times.

// File: rtl/hdb3_enc_pkg.sv
package hdb3_enc_pkg;

  // Contents of one look-ahead stage
  typedef enum logic [1:0] {
    SYM_EMPTY = 2'd0,  // no valid bit since reset
    SYM_ZERO  = 2'd1,  // data zero, not yet part of a substitution
    SYM_ONE   = 2'd2,  // data one
    SYM_VIOL  = 2'd3   // zero already replaced by a violation pulse
  } sym_t;

  // What the output stage sends during the current bit period
  typedef enum logic [1:0] {
    EMIT_SPACE = 2'd0,
    EMIT_MARK  = 2'd1,  // alternating mark (data one or B pulse)
    EMIT_VIOL  = 2'd2   // same polarity as the previous pulse
  } emit_t;

endpackage

// File: rtl/hdb3_lookahead.sv
module hdb3_lookahead
  import hdb3_enc_pkg::*;
#(
  parameter int RUN_LEN = 4
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  nrz_in,
  input  logic  hdb3_en,
  input  logic  parity_odd,
  output emit_t head_emit
);

  localparam int HEAD = RUN_LEN - 1;

  sym_t stage_q [RUN_LEN];
  logic all_zero;
  logic subst;

  // A substitution starts when every held stage is an untouched zero
  always_comb begin
    all_zero = 1'b1;
    for (int i = 0; i < RUN_LEN; i++) begin
      if (stage_q[i] != SYM_ZERO) all_zero = 1'b0;
    end
  end

  assign subst = hdb3_en & all_zero;

  // Head symbol: B pulse only when the mark count is even
  always_comb begin
    case (stage_q[HEAD])
      SYM_ONE:  head_emit = EMIT_MARK;
      SYM_VIOL: head_emit = EMIT_VIOL;
      SYM_ZERO: head_emit = (subst && !parity_odd) ? EMIT_MARK : EMIT_SPACE;
      default:  head_emit = EMIT_SPACE;
    endcase
  end

  // Shift; the youngest zero of a substituted group becomes the V
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < RUN_LEN; i++) stage_q[i] <= SYM_EMPTY;
    end else begin
      stage_q[0] <= nrz_in ? SYM_ONE : SYM_ZERO;
      for (int i = 1; i < RUN_LEN; i++) begin
        stage_q[i] <= (i == 1 && subst) ? SYM_VIOL : stage_q[i-1];
      end
    end
  end

endmodule

// File: rtl/hdb3_polarity_track.sv
module hdb3_polarity_track
  import hdb3_enc_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  emit_t head_emit,
  output logic  parity_odd,
  output logic  pos_next,
  output logic  neg_next
);

  logic last_pos;  // 1: previous pulse was positive

  always_comb begin
    pos_next = 1'b0;
    neg_next = 1'b0;
    case (head_emit)
      EMIT_MARK: begin
        pos_next = ~last_pos;
        neg_next = last_pos;
      end
      EMIT_VIOL: begin
        pos_next = last_pos;
        neg_next = ~last_pos;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_pos   <= 1'b0;
      parity_odd <= 1'b0;
    end else begin
      case (head_emit)
        EMIT_MARK: begin
          last_pos   <= ~last_pos;
          parity_odd <= ~parity_odd;
        end
        EMIT_VIOL: parity_odd <= 1'b0;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/hdb3_rz_shaper.sv
module hdb3_rz_shaper (
  input  logic clk,
  input  logic rst,
  input  logic pos_next,
  input  logic neg_next,
  output logic pos_hold,
  output logic neg_hold,
  output logic pos_rz,
  output logic neg_rz
);

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_hold <= 1'b0;
      neg_hold <= 1'b0;
    end else begin
      pos_hold <= pos_next;
      neg_hold <= neg_next;
    end
  end

  // Return to zero during the low clock phase
  assign pos_rz = pos_hold & clk;
  assign neg_rz = neg_hold & clk;

endmodule

// File: rtl/hdb3_ami_encoder.sv
module hdb3_ami_encoder #(
  parameter int RUN_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic nrz_in,
  input  logic hdb3_mode,
  output logic pos_rz,
  output logic neg_rz
);

  import hdb3_enc_pkg::*;

  emit_t head_emit;
  logic  parity_odd;
  logic  pos_next;
  logic  neg_next;
  logic  pos_hold;
  logic  neg_hold;

  hdb3_lookahead #(.RUN_LEN(RUN_LEN)) u_look (
    .clk        (clk),
    .rst        (rst),
    .nrz_in     (nrz_in),
    .hdb3_en    (hdb3_mode),
    .parity_odd (parity_odd),
    .head_emit  (head_emit)
  );

  hdb3_polarity_track u_pol (
    .clk        (clk),
    .rst        (rst),
    .head_emit  (head_emit),
    .parity_odd (parity_odd),
    .pos_next   (pos_next),
    .neg_next   (neg_next)
  );

  hdb3_rz_shaper u_rz (
    .clk      (clk),
    .rst      (rst),
    .pos_next (pos_next),
    .neg_next (neg_next),
    .pos_hold (pos_hold),
    .neg_hold (neg_hold),
    .pos_rz   (pos_rz),
    .neg_rz   (neg_rz)
  );

endmodule

// File: rtl/hdb3_ami_encoder_chk.sv
module hdb3_ami_encoder_chk #(
  parameter int RUN_LEN = 4
) (
  input logic clk,
  input logic rst,
  input logic nrz_in,
  input logic hdb3_mode,
  input logic pos_hold,
  input logic neg_hold
);

  localparam int          WIN   = 2 * RUN_LEN + 2;
  localparam logic [15:0] QUIET = 16'(RUN_LEN);
  localparam logic [15:0] FULL  = 16'(WIN);

  logic [15:0]      since_rst;
  logic [RUN_LEN:0] nrz_hist;
  logic [WIN-1:0]   ami_hist;
  logic             last_pos;
  logic             any_pulse;
  logic             pulse_d1;
  logic             pulse_d2;
  logic             pulse_now;

  assign pulse_now = pos_hold | neg_hold;

  always_ff @(posedge clk) begin
    nrz_hist <= {nrz_hist[RUN_LEN-1:0], nrz_in};
    ami_hist <= {ami_hist[WIN-2:0], ~hdb3_mode};
    if (rst) begin
      since_rst <= '0;
      last_pos  <= 1'b0;
      any_pulse <= 1'b0;
      pulse_d1  <= 1'b0;
      pulse_d2  <= 1'b0;
    end else begin
      if (since_rst <= FULL) since_rst <= since_rst + 16'd1;
      if (pulse_now) last_pos <= pos_hold;
      any_pulse <= any_pulse | pulse_now;
      pulse_d1  <= pulse_now;
      pulse_d2  <= pulse_d1;
    end
  end

  // R1: nothing leaves the block until the first real bit reaches the output
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    (since_rst <= QUIET) |-> !pulse_now);

  // R8: rails mutually exclusive
  a_r8_rails_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(pos_hold && neg_hold));

  // R3 and R2: in a settled AMI stretch a pulse mirrors the bit from RUN_LEN edges earlier
  a_r3_ami_follows_data: assert property (@(posedge clk) disable iff (rst)
    ((since_rst > FULL) && (&ami_hist)) |-> (pulse_now == nrz_hist[RUN_LEN]));

  // R4: first pulse after reset is positive
  a_r4_first_mark_positive: assert property (@(posedge clk) disable iff (rst)
    (!any_pulse && pulse_now) |-> pos_hold);

  // R6: a repeated polarity (a V) always follows two empty bit periods
  a_r6_viol_after_spaces: assert property (@(posedge clk) disable iff (rst)
    (any_pulse && ((pos_hold && last_pos) || (neg_hold && !last_pos)))
      |-> (!pulse_d1 && !pulse_d2));

endmodule

bind hdb3_ami_encoder hdb3_ami_encoder_chk #(.RUN_LEN(RUN_LEN)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .nrz_in    (nrz_in),
  .hdb3_mode (hdb3_mode),
  .pos_hold  (pos_hold),
  .neg_hold  (neg_hold)
);

// File: tb/hdb3_ami_encoder_tb_top.sv
`timescale 1ns/1ps
module hdb3_ami_encoder_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic nrz_in = 1'b0;
  logic hdb3_mode = 1'b0;
  logic pos_rz;
  logic neg_rz;

  int total = 0;
  int bad = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  hdb3_ami_encoder dut_i (
    .clk       (clk),
    .rst       (rst),
    .nrz_in    (nrz_in),
    .hdb3_mode (hdb3_mode),
    .pos_rz    (pos_rz),
    .neg_rz    (neg_rz)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: queue of held bits (0 zero, 1 one, 2 forced V)
  int q[$];
  bit m_last_pos = 1'b0;
  bit m_odd = 1'b0;
  bit exp_p = 1'b0;
  bit exp_n = 1'b0;
  int seen[$];

  always @(posedge clk) begin
    int sym;
    int f;
    sym = 0;
    if (rst) begin
      q.delete();
      m_last_pos = 1'b0;
      m_odd = 1'b0;
    end else begin
      if (q.size() == 4) begin
        f = q.pop_front();
        if (f == 2) sym = 2;
        else if (f == 1) sym = 1;
        else if (hdb3_mode && q[0] == 0 && q[1] == 0 && q[2] == 0) begin
          q[2] = 2;
          sym = m_odd ? 0 : 1;
        end
      end
      q.push_back(nrz_in ? 1 : 0);
    end
    exp_p = 1'b0;
    exp_n = 1'b0;
    if (sym == 1) begin
      exp_p = !m_last_pos;
      exp_n = m_last_pos;
      m_last_pos = !m_last_pos;
      m_odd = !m_odd;
    end else if (sym == 2) begin
      exp_p = m_last_pos;
      exp_n = !m_last_pos;
      m_odd = 1'b0;
    end
    #1;
    chk(cur_req, int'(pos_rz), int'(exp_p));
    chk(cur_req, int'(neg_rz), int'(exp_n));
    if (pos_rz && neg_rz) chk("R8", 1, 0);
    if (!rst) seen.push_back(pos_rz ? 1 : (neg_rz ? -1 : 0));
  end

  // R8: low clock phase is always quiet
  always @(negedge clk) begin
    #1;
    chk("R8", int'(pos_rz | neg_rz), 0);
  end

  // Reset, then play pat from the release edge on; exp uses '+', '-', '0'
  task automatic run_pattern(string req, bit mode, string pat, string exp);
    @(negedge clk);
    rst = 1'b1;
    cur_req = "R1";
    repeat (2) @(negedge clk);
    hdb3_mode = mode;
    for (int i = 0; i < pat.len() + 8; i++) begin
      nrz_in = (i < pat.len()) ? (pat[i] == "1") : 1'b1;
      if (i == 0) begin
        rst = 1'b0;
        seen.delete();
      end
      @(negedge clk);
    end
    for (int i = 0; i < 4; i++) chk("R1 quiet", seen[i], 0);
    for (int i = 0; i < exp.len(); i++) begin
      int e;
      e = (exp[i] == "+") ? 1 : ((exp[i] == "-") ? -1 : 0);
      chk(req, seen[4 + i], e);
    end
  endtask

  task automatic random_run(string req, int n, int density, bit flip);
    cur_req = req;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      nrz_in = ($urandom_range(99) < density);
      if (flip && ($urandom_range(63) == 0)) hdb3_mode = ~hdb3_mode;
    end
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R4 first mark positive; R5 odd count -> 000V; R2 position of bit 0
    run_pattern("R5 R4 R2", 1'b1, "100001", "+000+-");
    // R5 even count -> B00V twice; R6 V matches the preceding pulse
    run_pattern("R5 R6", 1'b1, "0000110000", "+00+-+-00-");
    // R3 AMI: long zero run left alone
    run_pattern("R3", 1'b0, "11000001", "+-00000+");
    // R7 eight zeros: 000V then B00V
    run_pattern("R7", 1'b1, "1000000001", "+000+-00-+");
    // R9 short runs not substituted
    run_pattern("R9", 1'b1, "10001001", "+000-00+");
    // random streams against the queue model
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    hdb3_mode = 1'b0;
    random_run("R3", 1500, 50, 1'b0);
    hdb3_mode = 1'b1;
    random_run("R5", 1500, 20, 1'b0);
    random_run("R6", 1500, 60, 1'b0);
    random_run("R7", 1000, 5, 1'b0);
    random_run("R2", 3000, 35, 1'b1);
    @(negedge clk);
    rst = 1'b1;
    cur_req = "R1";
    repeat (3) @(negedge clk);
    rst = 1'b0;
    hdb3_mode = 1'b1;
    random_run("R4", 800, 40, 1'b1);
    repeat (10) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule